// File: doc/BRIEF.md
# Hashed Page Table Walker

The walker turns a 32-bit data effective address into a physical address. It searches a hashed translation table that lives in ordinary memory. The top four address bits pick one of sixteen segment registers, and each of those holds a 24-bit segment space identifier. A table register gives the table origin and size mask, in 64 KiB units. From these the walker forms a primary group address and a secondary group address. It reads 8-byte entries over a single-word memory read port, one entry at a time, and stops at the first entry that matches. It then returns hit or miss together with the physical address. When an access needs the referenced or changed flag to be set, the walker writes the updated lower word of the entry back to memory.

Requests enter on a valid/ready channel and results leave on a second valid/ready channel. Only one walk is in flight at a time: `req_ready` stays low from acceptance until the result has been taken, and a result that is held off by `rsp_ready` stays frozen. A request can arrive marked as already translated by an outside block-translation unit. That hit wins: the walker returns the supplied address and touches no memory. The segment and table registers can be written only while the walker is idle, and `cfg_ready` reports when that is. A register write made in the same cycle that a request is accepted applies to that walk.

Top module: `hpt_walker`

## Requirements
- R1: After reset, `req_ready` and `cfg_ready` are 1, and `rsp_valid`, `mem_rd_en` and `mem_wr_en` are 0. All segment identifiers and both table fields are 0.
- R2: Page index = ea[31:12]. The segment register is ea[31:28]. The primary hash is {8'b0, space} XOR {12'b0, page index}. The group address is ((hash << 6) AND {mask, 16'hFFFF}) OR {origin, 16'h0000}. Slot n of a group sits at group + 8n.
- R3: Entry upper word: bit 31 valid, bits [30:7] space identifier, bit 6 group flag, bits [5:0] page tag. An entry matches only when it is valid, its identifier equals the segment's identifier, its tag equals ea[27:22], and its group flag equals 0 in the primary group or 1 in the secondary group.
- R4: The search visits primary slots 0..7 and then secondary slots 0..7. The first matching entry wins. Invalidating that entry exposes the next match in the same order.
- R5: The secondary group uses the bitwise complement of the primary hash in the R2 formula.
- R6: Entry lower word: bits [31:12] frame number, bit 8 referenced, bit 7 changed. On a hit, `rsp_pa` = {frame number, ea[11:0]} and `rsp_hit` = 1.
- R7: When none of the 16 entries matches, the result is `rsp_hit` = 0 and `rsp_pa` = 0. A slot whose upper word does not match costs one read, so a full miss issues exactly 16 reads.
- R8: A read hit with referenced = 0 writes back the lower word with bit 8 set. A write hit with referenced = 0 or changed = 0 writes it back with bits 8 and 7 set. The write goes to entry + 4. A hit that needs no flag change writes nothing.
- R9: A request with `req_blk_hit` = 1 returns `rsp_hit` = 1 and `rsp_pa` = `req_blk_pa` on the next cycle, without any memory access.
- R10: Origin bits that overlap ones in the mask, and zero holes inside the mask, act through the OR and AND of R2. There is no addition and the mask is not forced to be contiguous.
- R11: Segment and table writes take effect only while `cfg_ready` = 1. A write presented during a walk is dropped.
- R12: `req_ready` = 0 from acceptance until the result is accepted. While `rsp_valid` = 1 and `rsp_ready` = 0, `rsp_hit` and `rsp_pa` hold steady.
- R13: `mem_rd_en` holds `mem_rd_addr` steady until `mem_rd_valid` arrives. A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_seg_we | input | 1 | Segment register write strobe |
| cfg_seg_idx | input | 4 | Segment register index |
| cfg_seg_space | input | 24 | Segment space identifier to write |
| cfg_tbl_we | input | 1 | Table register write strobe |
| cfg_tbl_org | input | 16 | Table origin, address bits [31:16] |
| cfg_tbl_mask | input | 16 | Table mask, address bits [31:16] |
| cfg_ready | output | 1 | Register writes accepted (walker idle) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_ea | input | 32 | Effective address |
| req_write | input | 1 | Access is a store |
| req_blk_hit | input | 1 | External block translation already hit |
| req_blk_pa | input | 32 | Physical address from block translation |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken when high with valid |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | 32 | Physical address, 0 on miss |
| mem_rd_en | output | 1 | Read request, held until data returns |
| mem_rd_addr | output | 32 | Read byte address (word aligned) |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Read word, bit 31 is the lowest-addressed byte's MSB |
| mem_wr_en | output | 1 | One-cycle write of the entry lower word |
| mem_wr_addr | output | 32 | Write byte address |
| mem_wr_data | output | 32 | Updated lower word |

## Verification
The bench goes after four hazards. The first is shadowing: entries are stacked in primary and secondary slots and then invalidated one by one. A walker that searched in the wrong order, or that checked the group flag lazily, would return the wrong frame or report a hit on a stale entry. The second is misaligned origins and masks with holes. These aim at a walker that adds instead of ORing, or that assumes a contiguous mask; such a design reads the wrong group and misses. The third is the referenced/changed write-back: the bench counts writes to catch a walker that rewrites the entry when nothing changes, or that fails to mark a store. The fourth is register writes sent during a walk and results stalled by back-pressure. These expose a walker whose translation shifts in the middle of a walk, or whose output drifts while it waits.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int EA_W     = 32;
  localparam int PAGE_SH  = 12;
  localparam int PAGE_W   = EA_W - PAGE_SH;
  localparam int SPACE_W  = 24;
  localparam int TAG_W    = 6;
  localparam int TBL_W    = 16;
  localparam int FRAME_W  = 20;

  // entry upper word fields
  localparam int HI_VALID = 31;
  localparam int HI_SP_LSB = 7;
  localparam int HI_GRP   = 6;
  // entry lower word fields
  localparam int LO_REF   = 8;
  localparam int LO_CHG   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_HI,
    ST_CHECK,
    ST_READ_LO,
    ST_UPDATE,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/hpt_cfg_regs.sv
module hpt_cfg_regs
  import hpt_pkg::*;
#(
  parameter int NUM_SEGS = 16,
  parameter int IDX_W    = $clog2(NUM_SEGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_open,
  input  logic               seg_we,
  input  logic [IDX_W-1:0]   seg_idx,
  input  logic [SPACE_W-1:0] seg_space,
  input  logic               tbl_we,
  input  logic [TBL_W-1:0]   tbl_org_in,
  input  logic [TBL_W-1:0]   tbl_mask_in,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [SPACE_W-1:0] rd_space,
  output logic [TBL_W-1:0]   tbl_org,
  output logic [TBL_W-1:0]   tbl_mask
);
  logic [SPACE_W-1:0] seg_q [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n)
        seg_q[g] <= '0;
      else if (cfg_open && seg_we && (seg_idx == IDX_W'(g)))
        seg_q[g] <= seg_space;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_org  <= '0;
      tbl_mask <= '0;
    end else if (cfg_open && tbl_we) begin
      tbl_org  <= tbl_org_in;
      tbl_mask <= tbl_mask_in;
    end
  end

  assign rd_space = seg_q[rd_idx];

  // R11: translation inputs frozen while a walk is running
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(tbl_org) && $stable(tbl_mask) && $stable(rd_space)));
endmodule

// File: rtl/hpt_group_addr.sv
module hpt_group_addr
  import hpt_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic [SPACE_W-1:0] space,
  input  logic [PAGE_W-1:0]  page,
  input  logic               sec,
  input  logic [SLOT_W-1:0]  slot,
  input  logic [TBL_W-1:0]   tbl_org,
  input  logic [TBL_W-1:0]   tbl_mask,
  output logic [EA_W-1:0]    entry_addr
);
  localparam int GRP_SH = $clog2(SLOTS * 8);

  logic [EA_W-1:0] hash, hsel, grp, full_mask, full_org;

  always_comb begin
    hash      = {{(EA_W-SPACE_W){1'b0}}, space} ^ {{(EA_W-PAGE_W){1'b0}}, page};
    hsel      = sec ? ~hash : hash;
    full_mask = {tbl_mask, {(EA_W-TBL_W){1'b1}}};
    full_org  = {tbl_org, {(EA_W-TBL_W){1'b0}}};
    grp       = ((hsel << GRP_SH) & full_mask) | full_org;
    entry_addr = grp + (EA_W'(slot) << 3);
  end
endmodule

// File: rtl/hpt_entry_eval.sv
module hpt_entry_eval
  import hpt_pkg::*;
(
  input  logic [31:0]        hi,
  input  logic [31:0]        lo,
  input  logic [SPACE_W-1:0] space,
  input  logic [TAG_W-1:0]   tag,
  input  logic               sec,
  input  logic               wr,
  output logic               match,
  output logic               need_upd,
  output logic [31:0]        lo_new
);
  always_comb begin
    match = hi[HI_VALID]
          && (hi[HI_SP_LSB +: SPACE_W] == space)
          && (hi[HI_GRP] == sec)
          && (hi[TAG_W-1:0] == tag);
    need_upd = !lo[LO_REF] || (wr && !lo[LO_CHG]);
    lo_new = lo;
    lo_new[LO_REF] = 1'b1;
    if (wr) lo_new[LO_CHG] = 1'b1;
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int NUM_SEGS = 16,
  parameter int SLOTS    = 8,
  parameter int IDX_W    = $clog2(NUM_SEGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_seg_we,
  input  logic [IDX_W-1:0]   cfg_seg_idx,
  input  logic [SPACE_W-1:0] cfg_seg_space,
  input  logic               cfg_tbl_we,
  input  logic [TBL_W-1:0]   cfg_tbl_org,
  input  logic [TBL_W-1:0]   cfg_tbl_mask,
  output logic               cfg_ready,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [EA_W-1:0]    req_ea,
  input  logic               req_write,
  input  logic               req_blk_hit,
  input  logic [EA_W-1:0]    req_blk_pa,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_hit,
  output logic [EA_W-1:0]    rsp_pa,
  output logic               mem_rd_en,
  output logic [EA_W-1:0]    mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [31:0]        mem_rd_data,
  output logic               mem_wr_en,
  output logic [EA_W-1:0]    mem_wr_addr,
  output logic [31:0]        mem_wr_data
);
  localparam int SLOT_W = $clog2(SLOTS);

  walk_state_e        state_q;
  logic [EA_W-1:0]    ea_q;
  logic               wr_q, sec_q, hit_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [31:0]        hi_q, lo_q;
  logic [EA_W-1:0]    pa_q;

  logic [SPACE_W-1:0] space;
  logic [TBL_W-1:0]   tbl_org, tbl_mask;
  logic [EA_W-1:0]    entry_addr;
  logic               match, need_upd, last_slot;
  logic [31:0]        lo_new;

  assign cfg_ready = (state_q == ST_IDLE);

  hpt_cfg_regs #(.NUM_SEGS(NUM_SEGS), .IDX_W(IDX_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_open    (cfg_ready),
    .seg_we      (cfg_seg_we),
    .seg_idx     (cfg_seg_idx),
    .seg_space   (cfg_seg_space),
    .tbl_we      (cfg_tbl_we),
    .tbl_org_in  (cfg_tbl_org),
    .tbl_mask_in (cfg_tbl_mask),
    .rd_idx      (ea_q[EA_W-1 -: IDX_W]),
    .rd_space    (space),
    .tbl_org     (tbl_org),
    .tbl_mask    (tbl_mask)
  );

  hpt_group_addr #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_addr (
    .space      (space),
    .page       (ea_q[EA_W-1:PAGE_SH]),
    .sec        (sec_q),
    .slot       (slot_q),
    .tbl_org    (tbl_org),
    .tbl_mask   (tbl_mask),
    .entry_addr (entry_addr)
  );

  hpt_entry_eval u_eval (
    .hi       (hi_q),
    .lo       (lo_q),
    .space    (space),
    .tag      (ea_q[27:22]),
    .sec      (sec_q),
    .wr       (wr_q),
    .match    (match),
    .need_upd (need_upd),
    .lo_new   (lo_new)
  );

  assign last_slot = (slot_q == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      wr_q    <= 1'b0;
      sec_q   <= 1'b0;
      slot_q  <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      hit_q   <= 1'b0;
      pa_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            ea_q   <= req_ea;
            wr_q   <= req_write;
            sec_q  <= 1'b0;
            slot_q <= '0;
            if (req_blk_hit) begin
              hit_q   <= 1'b1;
              pa_q    <= req_blk_pa;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_READ_HI;
            end
          end
        end
        ST_READ_HI: begin
          if (mem_rd_valid) begin
            hi_q    <= mem_rd_data;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (match) begin
            state_q <= ST_READ_LO;
          end else if (sec_q && last_slot) begin
            hit_q   <= 1'b0;
            pa_q    <= '0;
            state_q <= ST_DONE;
          end else begin
            if (last_slot) begin
              sec_q  <= 1'b1;
              slot_q <= '0;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
            state_q <= ST_READ_HI;
          end
        end
        ST_READ_LO: begin
          if (mem_rd_valid) begin
            lo_q    <= mem_rd_data;
            state_q <= ST_UPDATE;
          end
        end
        ST_UPDATE: begin
          hit_q   <= 1'b1;
          pa_q    <= {lo_q[31:PAGE_SH], ea_q[PAGE_SH-1:0]};
          state_q <= ST_DONE;
        end
        ST_DONE: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign rsp_valid   = (state_q == ST_DONE);
  assign rsp_hit     = hit_q;
  assign rsp_pa      = pa_q;

  assign mem_rd_en   = (state_q == ST_READ_HI) || (state_q == ST_READ_LO);
  assign mem_rd_addr = (state_q == ST_READ_LO) ? {entry_addr[EA_W-1:3], 3'b100} : entry_addr;
  assign mem_wr_en   = (state_q == ST_UPDATE) && need_upd;
  assign mem_wr_addr = {entry_addr[EA_W-1:3], 3'b100};
  assign mem_wr_data = lo_new;

  // R12: held result does not drift under back-pressure
  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_pa)));

  // R12: no second request while a result is pending
  a_r12_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R9: bypass hit answers on the next cycle with its own address
  a_r9_bypass_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_blk_hit) |=>
      (rsp_valid && rsp_hit && (rsp_pa == $past(req_blk_pa))));

  // R8: write-back lands on the lower word and marks it referenced
  a_r8_wr_lower_word: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ((mem_wr_addr[2:0] == 3'b100) && mem_wr_data[LO_REF]));

  // R13: read and write never share a cycle
  a_r13_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  // R13: pending read keeps its address
  a_r13_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr)));
endmodule

// File: tb/hpt_walker_bench.sv
`timescale 1ns/1ps
module hpt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_seg_we = 1'b0;
  logic [3:0]  cfg_seg_idx = '0;
  logic [23:0] cfg_seg_space = '0;
  logic        cfg_tbl_we = 1'b0;
  logic [15:0] cfg_tbl_org = '0, cfg_tbl_mask = '0;
  logic        cfg_ready;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_ea = '0;
  logic        req_write = 1'b0, req_blk_hit = 1'b0;
  logic [31:0] req_blk_pa = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_hit;
  logic [31:0] rsp_pa;
  logic        mem_rd_en, mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_addr, mem_rd_data = '0;
  logic        mem_wr_en;
  logic [31:0] mem_wr_addr, mem_wr_data;

  always #10 clk = ~clk;

  hpt_walker u_hpt_walker (
    .clk(clk), .rst_n(rst_n),
    .cfg_seg_we(cfg_seg_we), .cfg_seg_idx(cfg_seg_idx), .cfg_seg_space(cfg_seg_space),
    .cfg_tbl_we(cfg_tbl_we), .cfg_tbl_org(cfg_tbl_org), .cfg_tbl_mask(cfg_tbl_mask),
    .cfg_ready(cfg_ready),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea), .req_write(req_write),
    .req_blk_hit(req_blk_hit), .req_blk_pa(req_blk_pa),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  // sparse memory model, one-cycle read latency
  logic [31:0] mem [int unsigned];
  int rd_cnt = 0, wr_cnt = 0, clash_cnt = 0;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= mem_rd_en && !mem_rd_valid;
    mem_rd_data  <= mrd(mem_rd_addr);
    if (mem_rd_en && mem_rd_valid) rd_cnt = rd_cnt + 1;
    if (mem_wr_en) begin
      mem[mem_wr_addr] = mem_wr_data;
      wr_cnt = wr_cnt + 1;
    end
    if (mem_rd_en && mem_wr_en) clash_cnt = clash_cnt + 1;
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench-side copy of the programmed registers, used by the R2 formula
  logic [23:0] tb_seg [16];
  logic [15:0] tb_org = '0, tb_mask = '0;

  function automatic logic [31:0] grp(input logic [31:0] ea, input logic sec);
    logic [31:0] h;
    h = {8'h0, tb_seg[ea[31:28]]} ^ {12'h0, ea[31:12]};
    if (sec) h = ~h;
    return ((h << 6) & {tb_mask, 16'hFFFF}) | {tb_org, 16'h0};
  endfunction

  task automatic put_raw(input logic [31:0] a, input logic [31:0] hi, input logic [31:0] lo);
    mem[a]      = hi;
    mem[a + 4]  = lo;
  endtask

  function automatic logic [31:0] lo_word(input logic [19:0] frame, input logic r, input logic c);
    return {frame, 3'b000, r, c, 7'b0000010};
  endfunction

  task automatic put(input logic [31:0] ea, input logic sec, input int slot,
                     input logic [19:0] frame, input logic r, input logic c);
    put_raw(grp(ea, sec) + slot * 8, {1'b1, tb_seg[ea[31:28]], sec, ea[27:22]},
            lo_word(frame, r, c));
  endtask

  task automatic kill(input logic [31:0] ea, input logic sec, input int slot);
    logic [31:0] a;
    a = grp(ea, sec) + slot * 8;
    mem[a] = {1'b0, mrd(a)[30:0]};
  endtask

  task automatic set_seg(input int idx, input logic [23:0] sp);
    @(negedge clk);
    cfg_seg_we = 1'b1; cfg_seg_idx = 4'(idx); cfg_seg_space = sp;
    @(negedge clk);
    cfg_seg_we = 1'b0;
    tb_seg[idx] = sp;
  endtask

  task automatic set_tbl(input logic [15:0] org, input logic [15:0] msk);
    @(negedge clk);
    cfg_tbl_we = 1'b1; cfg_tbl_org = org; cfg_tbl_mask = msk;
    @(negedge clk);
    cfg_tbl_we = 1'b0;
    tb_org = org; tb_mask = msk;
  endtask

  task automatic walk(input logic [31:0] ea, input logic wr, input logic blk,
                      input logic [31:0] bpa, output logic hit, output logic [31:0] pa);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_write = wr; req_blk_hit = blk; req_blk_pa = bpa;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_blk_hit = 1'b0;
    while (!rsp_valid) @(negedge clk);
    hit = rsp_hit; pa = rsp_pa;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] ea;
    logic        wr;
    logic        hit;
    logic [31:0] pa;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{32'h1010_0123, 1'b0, 1'b1, 32'h0010_0123},   // R2 R6 primary slot 0
    '{32'h1010_1ABC, 1'b0, 1'b1, 32'h0055_5ABC},   // R2 primary slot 5
    '{32'h1020_0000, 1'b0, 1'b1, 32'h0022_2000},   // R5 secondary slot 2
    '{32'h2013_0FFF, 1'b0, 1'b1, 32'h0013_0FFF},   // R2 other segment, slot 7
    '{32'h3013_0000, 1'b0, 1'b0, 32'h0000_0000},   // R7 no entry for segment
    '{32'h1030_0000, 1'b0, 1'b0, 32'h0000_0000},   // R3 wrong group flag / invalid
    '{32'h1040_0000, 1'b1, 1'b0, 32'h0000_0000}    // R3 wrong tag
  };

  initial begin
    logic        h;
    logic [31:0] p, a;
    int          r0, w0;
    for (int i = 0; i < 16; i++) tb_seg[i] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state: {req_ready, cfg_ready, rsp_valid, mem_rd_en, mem_wr_en}
    chk("R1 reset outputs", {27'h0, req_ready, cfg_ready, rsp_valid, mem_rd_en, mem_wr_en},
        32'b11000);
    walk(32'h1010_0000, 1'b0, 1'b0, 32'h0, h, p);
    chk("R1 cleared registers give miss", {31'h0, h}, 32'h0);

    set_seg(1, 24'h00007B);
    set_seg(2, 24'h000ABC);
    set_tbl(16'h0002, 16'h0000);

    put(32'h1010_0123, 1'b0, 0, 20'h00100, 1'b1, 1'b1);
    put(32'h1010_1ABC, 1'b0, 5, 20'h00555, 1'b1, 1'b1);
    put(32'h1020_0000, 1'b1, 2, 20'h00222, 1'b1, 1'b1);
    put(32'h2013_0FFF, 1'b0, 7, 20'h00130, 1'b1, 1'b1);
    a = grp(32'h1030_0000, 1'b0);
    put_raw(a,     {1'b1, tb_seg[1], 1'b1, 6'h00}, lo_word(20'h00AAA, 1'b1, 1'b1));
    put_raw(a + 8, {1'b0, tb_seg[1], 1'b0, 6'h00}, lo_word(20'h00BBB, 1'b1, 1'b1));
    put_raw(grp(32'h1030_0000, 1'b1), {1'b1, tb_seg[1], 1'b0, 6'h00},
            lo_word(20'h00CCC, 1'b1, 1'b1));
    put_raw(grp(32'h1040_0000, 1'b0) + 8, {1'b1, tb_seg[1], 1'b0, 6'h00},
            lo_word(20'h00DDD, 1'b1, 1'b1));

    foreach (VECS[i]) begin
      walk(VECS[i].ea, VECS[i].wr, 1'b0, 32'h0, h, p);
      chk($sformatf("R3 R6 vector %0d hit", i), {31'h0, h}, {31'h0, VECS[i].hit});
      chk($sformatf("R2 R6 vector %0d pa", i), p, VECS[i].pa);
    end

    // R4 ordering and exposure after invalidation
    put(32'h1018_0000, 1'b1, 2, 20'h0000A, 1'b1, 1'b1);
    walk(32'h1018_0000, 1'b0, 1'b0, 0, h, p); chk("R4 secondary slot 2", p, 32'h0000_A000);
    put(32'h1018_0000, 1'b1, 0, 20'h0000B, 1'b1, 1'b1);
    walk(32'h1018_0000, 1'b0, 1'b0, 0, h, p); chk("R4 secondary slot 0 first", p, 32'h0000_B000);
    put(32'h1018_0000, 1'b0, 4, 20'h0000C, 1'b1, 1'b1);
    walk(32'h1018_0000, 1'b0, 1'b0, 0, h, p); chk("R4 primary beats secondary", p, 32'h0000_C000);
    put(32'h1018_0000, 1'b0, 1, 20'h0000D, 1'b1, 1'b1);
    walk(32'h1018_0000, 1'b0, 1'b0, 0, h, p); chk("R4 primary slot 1 first", p, 32'h0000_D000);
    kill(32'h1018_0000, 1'b0, 1);
    walk(32'h1018_0000, 1'b0, 1'b0, 0, h, p); chk("R4 expose primary slot 4", p, 32'h0000_C000);
    kill(32'h1018_0000, 1'b0, 4);
    walk(32'h1018_0000, 1'b0, 1'b0, 0, h, p); chk("R4 expose secondary slot 0", p, 32'h0000_B000);
    kill(32'h1018_0000, 1'b1, 0);
    walk(32'h1018_0000, 1'b0, 1'b0, 0, h, p); chk("R4 expose secondary slot 2", p, 32'h0000_A000);

    // R7 full miss with all 16 slots holding non-matching entries
    for (int s = 0; s < 8; s++) begin
      put_raw(grp(32'h1057_0000, 1'b0) + s * 8, {1'b1, tb_seg[1], 1'b0, 6'h3F},
              lo_word(20'h00EEE, 1'b1, 1'b1));
      put_raw(grp(32'h1057_0000, 1'b1) + s * 8, {1'b1, tb_seg[1], 1'b1, 6'h3F},
              lo_word(20'h00EEE, 1'b1, 1'b1));
    end
    r0 = rd_cnt;
    walk(32'h1057_0000, 1'b0, 1'b0, 0, h, p);
    chk("R7 full miss hit", {31'h0, h}, 32'h0);
    chk("R7 full miss pa", p, 32'h0);
    chk("R7 full miss read count", 32'(rd_cnt - r0), 32'd16);

    // R9 bypass wins over a mapped entry, no memory traffic
    r0 = rd_cnt;
    walk(32'h1010_0123, 1'b0, 1'b1, 32'h0014_0123, h, p);
    chk("R9 bypass pa", p, 32'h0014_0123);
    chk("R9 bypass no reads", 32'(rd_cnt - r0), 32'd0);

    // R8 referenced / changed write-back
    put(32'h101F_0000, 1'b0, 3, 20'h001F0, 1'b0, 1'b0);
    a = grp(32'h101F_0000, 1'b0) + 3 * 8 + 4;
    w0 = wr_cnt;
    walk(32'h101F_0000, 1'b0, 1'b0, 0, h, p);
    chk("R8 read hit pa", p, 32'h001F_0000);
    chk("R8 read sets referenced only", {30'h0, mrd(a)[8:7]}, 32'b10);
    chk("R8 one write on read", 32'(wr_cnt - w0), 32'd1);
    w0 = wr_cnt;
    walk(32'h101F_0000, 1'b0, 1'b0, 0, h, p);
    chk("R8 no write when referenced set", 32'(wr_cnt - w0), 32'd0);
    walk(32'h101F_0000, 1'b1, 1'b0, 0, h, p);
    chk("R8 write sets changed", {30'h0, mrd(a)[8:7]}, 32'b11);
    chk("R8 frame kept", {12'h0, mrd(a)[31:12]}, 32'h001F0);
    w0 = wr_cnt;
    walk(32'h101F_0000, 1'b1, 1'b0, 0, h, p);
    chk("R8 no write when both set", 32'(wr_cnt - w0), 32'd0);
    put(32'h101F_0000, 1'b0, 3, 20'h001F0, 1'b0, 1'b0);
    walk(32'h101F_0000, 1'b1, 1'b0, 0, h, p);
    chk("R8 write from clear sets both", {30'h0, mrd(a)[8:7]}, 32'b11);

    // R11 and R12: register write during a walk, stalled result
    @(negedge clk);
    req_valid = 1'b1; req_ea = 32'h1010_0123; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 cfg_ready low while busy", {31'h0, cfg_ready}, 32'h0);
    cfg_seg_we = 1'b1; cfg_seg_idx = 4'd1; cfg_seg_space = 24'h000999;
    cfg_tbl_we = 1'b1; cfg_tbl_org = 16'h0007; cfg_tbl_mask = 16'h0000;
    @(negedge clk);
    cfg_seg_we = 1'b0; cfg_tbl_we = 1'b0;
    while (!rsp_valid) @(negedge clk);
    p = rsp_pa;
    repeat (3) @(negedge clk);
    chk("R12 rsp held valid", {31'h0, rsp_valid}, 32'h1);
    chk("R12 rsp pa stable", rsp_pa, p);
    chk("R12 no accept while pending", {31'h0, req_ready}, 32'h0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R12 idle after take", {31'h0, req_ready}, 32'h1);
    walk(32'h1010_0123, 1'b0, 1'b0, 0, h, p);
    chk("R11 dropped write leaves mapping", p, 32'h0010_0123);

    // R10 misaligned origin, then mask with a hole
    set_tbl(16'h0005, 16'h0003);
    put(32'h1063_0000, 1'b0, 0, 20'h00250, 1'b1, 1'b1);
    walk(32'h1063_0000, 1'b0, 1'b0, 0, h, p);
    chk("R10 misaligned origin OR", p, 32'h0025_0000);
    set_tbl(16'h0008, 16'h0002);
    put(32'h1063_0000, 1'b0, 0, 20'h002A0, 1'b1, 1'b1);
    walk(32'h1063_0000, 1'b0, 1'b0, 0, h, p);
    chk("R10 mask hole honoured", p, 32'h002A_0000);

    chk("R13 no read/write overlap", 32'(clash_cnt), 32'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule